// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Unit

This unit keeps the interrupt status flags of a USB function controller for two endpoints: the control endpoint 0 and a bulk IN endpoint 2. Endpoint 2 sends from a pair of alternating transmit buffers. The packet engine sends single-cycle event pulses into the unit: a setup command that needs firmware decoding was acknowledged, OUT data was stored and acknowledged, an IN token arrived, and IN data went out and the host acknowledged it. Each pulse sets its own sticky flag. The CPU reads the flags and clears them by writing 0 to a bit.

The same IN-token pulse also chooses the handshake for endpoint 0. If the transmit FIFO holds valid data and firmware has enabled transmission, the data phase goes ahead. Otherwise the unit answers NAK and raises a transfer-request flag.

The endpoint 2 empty flag is not stored. It follows buffer occupancy and cannot be cleared by the CPU. Writing 0 to that bit position instead cancels a separate DMA transfer-end request.

A second register holds one enable bit per flag. The interrupt output is the OR of every flag ANDed with its own enable bit.

Top module: `usb_ep_irq_flags`

## Requirements
- R1: After reset, bits 3 to 0 of the status register (read address 0) are 0. The enable register (read address 1) is 0, and irq and dma_irq are low.
- R2: Status bit 4 reads 1 while at least one endpoint 2 buffer is not full (any ep2_buf_full bit 0). It reads 0 when all the buffers are full.
- R3: A CPU write cannot change status bit 4. A status write with bit 4 = 0 clears the DMA transfer-end request (dma_irq). A write with bit 4 = 1 leaves that request unchanged. The request is set by ep2_dma_done.
- R4: ev_setup_ack sets status bit 3 in the next cycle.
- R5: ev_out_ack sets status bit 2 in the next cycle.
- R6: An ev_in_token while ep0_tx_valid is 0 drives in_nak high in the same cycle and sets status bit 1 in the next cycle. An ev_in_token while ep0_tx_valid is 1 drives in_send high, keeps in_nak low and leaves bit 1 unchanged.
- R7: ev_in_ack sets status bit 0 in the next cycle.
- R8: A status write (wr_addr = 0) clears each of bits 3 to 0 written as 0 and leaves each bit written as 1 unchanged.
- R9: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set. This includes the DMA request.
- R10: irq equals the OR over bits 4 to 0 of status ANDed with the enable register. The enable register is written and read at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_setup_ack | input | 1 | Setup command needing decode was acknowledged |
| ev_out_ack | input | 1 | Endpoint 0 OUT data stored and acknowledged |
| ev_in_token | input | 1 | IN token for endpoint 0 received |
| ev_in_ack | input | 1 | Endpoint 0 IN data sent, host returned ACK |
| ep0_tx_valid | input | 1 | Endpoint 0 FIFO holds data and transmission is enabled |
| ep2_buf_full | input | EP2_BUFS | Occupancy of each endpoint 2 transmit buffer |
| ep2_dma_done | input | 1 | DMA transfer-end event for endpoint 2 |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 1 | 0 = status, 1 = enable |
| wr_data | input | 5 | CPU write data |
| rd_addr | input | 1 | 0 = status, 1 = enable |
| rd_data | output | 5 | Read data for rd_addr |
| in_nak | output | 1 | Answer the current endpoint 0 IN token with NAK |
| in_send | output | 1 | Answer the current endpoint 0 IN token with data |
| irq | output | 1 | Enabled-flag interrupt |
| dma_irq | output | 1 | Pending endpoint 2 DMA transfer-end request |

## Verification
Two things can land on the same flag in one cycle: an event pulse from the packet engine and a CPU write that clears that flag. The bench drives ev_in_ack together with a status write that has bit 0 = 0, and ep2_dma_done together with a write that has bit 4 = 0. In both cases it expects the flag to read as set afterwards. It also writes 0 to bit 4 while both buffers are full and while one is free, and checks that only dma_irq changes and the empty flag keeps following occupancy.

// File: rtl/usb_ep_irq_flags.sv
module usb_ep_irq_flags #(
  parameter int EP2_BUFS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_setup_ack,
  input  logic                ev_out_ack,
  input  logic                ev_in_token,
  input  logic                ev_in_ack,
  input  logic                ep0_tx_valid,
  input  logic [EP2_BUFS-1:0] ep2_buf_full,
  input  logic                ep2_dma_done,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [4:0]          wr_data,
  input  logic                rd_addr,
  output logic [4:0]          rd_data,
  output logic                in_nak,
  output logic                in_send,
  output logic                irq,
  output logic                dma_irq
);
  localparam int FLAGW = 5;
  localparam int E0W   = FLAGW - 1;

  logic [E0W-1:0]   ep0_f;
  logic [FLAGW-1:0] ien;
  logic             dma_req;
  logic             ep2_empty;
  logic             st_wr, en_wr;
  logic [E0W-1:0]   ep0_set, ep0_clr;
  logic [FLAGW-1:0] status;

  assign st_wr     = wr_en & ~wr_addr;
  assign en_wr     = wr_en &  wr_addr;
  assign ep2_empty = ~&ep2_buf_full;
  assign in_nak    = ev_in_token & ~ep0_tx_valid;
  assign in_send   = ev_in_token &  ep0_tx_valid;

  assign ep0_set = {ev_setup_ack, ev_out_ack, in_nak, ev_in_ack};
  assign ep0_clr = st_wr ? ~wr_data[E0W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep0_f   <= '0;
      ien     <= '0;
      dma_req <= 1'b0;
    end else begin
      ep0_f   <= (ep0_f & ~ep0_clr) | ep0_set;
      dma_req <= ep2_dma_done | (dma_req & ~(st_wr & ~wr_data[E0W]));
      if (en_wr) ien <= wr_data;
    end
  end

  assign status  = {ep2_empty, ep0_f};
  assign irq     = |(status & ien);
  assign dma_irq = dma_req;
  assign rd_data = rd_addr ? ien : status;

  AST_SETUP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup_ack |=> status[3]);                                     // R4
  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out_ack |=> status[2]);                                       // R5
  AST_NAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in_token && !ep0_tx_valid) |=> status[1]);                   // R6
  AST_INACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_ack |=> status[0]);                                        // R7
  AST_W1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && (&wr_data[3:0]) && !ev_setup_ack && !ev_out_ack
     && !ev_in_token && !ev_in_ack) |=> $stable(status[3:0]));       // R8
  AST_DMA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !wr_data[4] && !ep2_dma_done) |=> !dma_irq);           // R3
  AST_DMA_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ep2_dma_done |=> dma_irq);                                       // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr && rd_data == '0) |-> !irq);                            // R10
endmodule

// File: tb/usb_ep_irq_flags_bench.sv
module usb_ep_irq_flags_bench;
  logic clk = 0, rst_n = 0;
  logic ev_setup_ack = 0, ev_out_ack = 0, ev_in_token = 0, ev_in_ack = 0;
  logic ep0_tx_valid = 0, ep2_dma_done = 0, wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [1:0] ep2_buf_full = 0;
  logic [4:0] wr_data = 0, rd_data;
  logic in_nak, in_send, irq, dma_irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  usb_ep_irq_flags u_usb_ep_irq_flags (.*);

  // {ev[setup,out,tok,inack], tv, full[1:0], dma, we, wa, wd[4:0], exp_st[4:0], exp_irq, exp_dma}
  localparam int NV = 20;
  localparam logic [21:0] VEC [NV] = '{
    {4'b0000,1'b0,2'b00,1'b0,1'b0,1'b0,5'b00000, 5'b10000,1'b0,1'b0}, // R2 both free
    {4'b0000,1'b0,2'b01,1'b0,1'b0,1'b0,5'b00000, 5'b10000,1'b0,1'b0}, // R2 one free
    {4'b0000,1'b0,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b00000,1'b0,1'b0}, // R2 none free
    {4'b1000,1'b0,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b01000,1'b0,1'b0}, // R4
    {4'b0100,1'b0,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b01100,1'b0,1'b0}, // R5
    {4'b0010,1'b0,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b01110,1'b0,1'b0}, // R6
    {4'b0001,1'b0,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b01111,1'b0,1'b0}, // R7
    {4'b0000,1'b0,2'b11,1'b0,1'b1,1'b0,5'b11111, 5'b01111,1'b0,1'b0}, // R8 ones hold
    {4'b0000,1'b0,2'b11,1'b0,1'b1,1'b0,5'b10111, 5'b00111,1'b0,1'b0}, // R8 clear bit3
    {4'b0000,1'b0,2'b11,1'b0,1'b1,1'b1,5'b00001, 5'b00111,1'b1,1'b0}, // R10 enable bit0
    {4'b0000,1'b0,2'b11,1'b0,1'b1,1'b0,5'b11110, 5'b00110,1'b0,1'b0}, // R8 clear bit0
    {4'b0001,1'b0,2'b11,1'b0,1'b1,1'b0,5'b11110, 5'b00111,1'b1,1'b0}, // R9 set wins
    {4'b0000,1'b0,2'b11,1'b1,1'b0,1'b0,5'b00000, 5'b00111,1'b1,1'b1}, // R3 dma set
    {4'b0000,1'b0,2'b11,1'b0,1'b1,1'b0,5'b11111, 5'b00111,1'b1,1'b1}, // R3 write 1 keeps
    {4'b0000,1'b0,2'b11,1'b0,1'b1,1'b0,5'b01111, 5'b00111,1'b1,1'b0}, // R3 write 0 clears req
    {4'b0000,1'b0,2'b10,1'b0,1'b1,1'b0,5'b00000, 5'b10000,1'b0,1'b0}, // R3 bit4 not clearable
    {4'b0000,1'b0,2'b10,1'b1,1'b1,1'b0,5'b01111, 5'b10000,1'b0,1'b1}, // R9 dma set wins
    {4'b0000,1'b0,2'b10,1'b0,1'b1,1'b1,5'b10000, 5'b10000,1'b1,1'b1}, // R10 enable bit4
    {4'b0000,1'b0,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b00000,1'b0,1'b1}, // R10 bit4 drops
    {4'b0010,1'b1,2'b11,1'b0,1'b0,1'b0,5'b00000, 5'b00000,1'b0,1'b1}  // R6 data ready
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2:            return "R2";
      3:                  return "R4";
      4:                  return "R5";
      5, 19:              return "R6";
      6:                  return "R7";
      7, 8, 10:           return "R8";
      11, 16:             return "R9";
      9, 17, 18:          return "R10";
      default:            return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    {ev_setup_ack, ev_out_ack, ev_in_token, ev_in_ack, ep2_dma_done, wr_en} = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1", rd_data, 5'b10000);
    rd_addr = 1; #1;
    chk("R1", rd_data, 5'b00000);
    chk("R1", {3'b0, irq, dma_irq}, 5'b0);
    rd_addr = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ev_setup_ack, ev_out_ack, ev_in_token, ev_in_ack} = VEC[i][21:18];
      ep0_tx_valid = VEC[i][17];
      ep2_buf_full = VEC[i][16:15];
      ep2_dma_done = VEC[i][14];
      wr_en = VEC[i][13];
      wr_addr = VEC[i][12];
      wr_data = VEC[i][11:7];
      @(posedge clk); #1;
      chk(req_of(i), rd_data, VEC[i][6:2]);
      chk(req_of(i), {4'b0, irq}, {4'b0, VEC[i][1]});
      chk(req_of(i), {4'b0, dma_irq}, {4'b0, VEC[i][0]});
    end

    @(negedge clk) idle();
    rd_addr = 1; #1;
    chk("R10", rd_data, 5'b10000);
    rd_addr = 0;

    // R6 handshake choice, same cycle as the token
    ev_in_token = 1; ep0_tx_valid = 0; #1;
    chk("R6", {3'b0, in_nak, in_send}, 5'b00010);
    ep0_tx_valid = 1; #1;
    chk("R6", {3'b0, in_nak, in_send}, 5'b00001);
    @(negedge clk) idle();
    #1 chk("R6", rd_data, 5'b00000);

    // R1 reset mid-run with flags and enables set
    ev_setup_ack = 1; ep2_buf_full = 2'b00;
    @(negedge clk) idle();
    rst_n = 0;
    @(negedge clk) rst_n = 1;
    #1 chk("R1", rd_data, 5'b10000);
    chk("R1", {3'b0, irq, dma_irq}, 5'b0);
    rd_addr = 1; #1;
    chk("R1", rd_data, 5'b00000);

    finish_run();
  end
endmodule